// File: doc/BRIEF.md
# Ethernet Network Octet Counter

This block keeps a running count of the bytes of frame data that pass through an Ethernet MAC in either direction. The count gives a rough measure of how busy the link is. The block only watches the MAC. It takes one strobe per byte from the transmit path and one from the receive path. It also takes single-cycle event pulses: collision, carrier loss, jam start and frame end, plus a flag that says the link runs in half duplex. Frame type, destination address, frame length and error conditions play no part. Runts, oversize frames and frames with CRC, alignment, code, overrun or underrun errors are counted like any other.

Two small state machines decide which strobes are counted. The transmit tracker has two states, `TXS_LIVE` and `TXS_BACKOFF`. A collision or carrier-loss pulse moves it from `TXS_LIVE` to `TXS_BACKOFF`. From that pulse on, transmit bytes are not counted until frame end moves it back to `TXS_LIVE`. A retry therefore adds its bytes again. The receive tracker has two states, `RXS_LIVE` and `RXS_JAM`. A jam-start pulse in half duplex moves it from `RXS_LIVE` to `RXS_JAM`. Frame end moves it back to `RXS_LIVE`. While it is jamming, neither the jam bytes on the transmit path nor the received bytes are counted. In full duplex the jam-start pulse does nothing.

Software reads the count directly from `octet_count`. A write subtracts the written value from the count. A write and an increment in the same cycle are applied together, in one step.

Top module: `octet_counter_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `octet_count` to 0 after that edge. Both trackers return to their live state.
- R2: A `tx_byte` strobe adds 1 to `octet_count` after the next edge when all of these hold: the transmit tracker is live, the receive tracker is not jamming, and neither an event pulse (collision, carrier loss) nor a half-duplex jam start arrives in the same cycle. With no strobe and no write, the count holds.
- R3: In full duplex (`half_duplex`=0), every `rx_byte` strobe adds 1. In half duplex, an `rx_byte` strobe adds 1 unless the receive tracker is jamming or `jam_start` is high in that cycle.
- R4: A transmit byte and a receive byte that both count in one cycle add 2 in that cycle.
- R5: A `collision` or `carrier_loss` pulse suppresses the transmit byte of its own cycle, and every later transmit byte, up to and including the cycle of the next `frame_end`. From the next cycle, transmit bytes count again, so each retry is counted in full.
- R6: A `jam_start` pulse with `half_duplex`=1 suppresses both transmit and receive bytes, from that cycle up to and including the next `frame_end` cycle. With `half_duplex`=0, `jam_start` has no effect on the count.
- R7: With `wr_en` high, the count after the edge equals the old count, plus the increments of that cycle, minus `wr_data`.
- R8: The count wraps modulo 2^32 in both directions. One increment from 0xFFFFFFFF gives 0. Subtracting more than the count wraps below 0.
- R9: A `frame_end` in the same cycle as a `collision` leaves the transmit tracker live for the next cycle. The byte of that cycle is still suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| half_duplex | input | 1 | 1 = half-duplex link |
| tx_byte | input | 1 | One transmit byte in this cycle |
| rx_byte | input | 1 | One receive byte in this cycle |
| collision | input | 1 | Collision pulse on the transmit attempt |
| carrier_loss | input | 1 | Carrier-loss pulse on the transmit attempt |
| jam_start | input | 1 | A flow-control jam starts this cycle |
| frame_end | input | 1 | The current frame or attempt ends this cycle |
| wr_en | input | 1 | Write strobe: subtract `wr_data` |
| wr_data | input | 32 | Value to subtract from the count |
| octet_count | output | 32 | Current byte count |

## Verification
Random byte streams with sparse event pulses, writes and duplex changes are checked cycle by cycle against a bench model. This tells apart wrong gating in each tracker state from wrong arithmetic in the adder. Directed runs cover the edge cases. A collision followed by a retry shows that the bytes of the retry are counted again and not lost. A jam in half duplex is set beside the same jam in full duplex to show that the duplex flag alone decides whether the pulse acts. A write in the same cycle as a double increment, and a run past 0xFFFFFFFF and below zero, separate the one-step net update and the modulo behaviour from updates applied one after the other.

// File: rtl/octet_cnt_pkg.sv
package octet_cnt_pkg;

    typedef enum logic {
        TXS_LIVE    = 1'b0,
        TXS_BACKOFF = 1'b1
    } tx_state_e;

    typedef enum logic {
        RXS_LIVE = 1'b0,
        RXS_JAM  = 1'b1
    } rx_state_e;

    localparam int unsigned MAX_STEP = 2;

endpackage

// File: rtl/octet_tx_track.sv
module octet_tx_track
    import octet_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tx_byte,
    input  logic collision,
    input  logic carrier_loss,
    input  logic frame_end,
    input  logic jam_block,
    output logic tx_count_en
);

    tx_state_e state_q;
    tx_state_e state_d;
    logic      attempt_cut;

    assign attempt_cut = collision | carrier_loss;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXS_LIVE: begin
                if (attempt_cut && !frame_end) begin
                    state_d = TXS_BACKOFF;
                end
            end
            TXS_BACKOFF: begin
                if (frame_end) begin
                    state_d = TXS_LIVE;
                end
            end
            default: state_d = TXS_LIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TXS_LIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // output logic
    always_comb begin
        tx_count_en = 1'b0;
        unique case (state_q)
            TXS_LIVE:    tx_count_en = tx_byte && !attempt_cut && !jam_block;
            TXS_BACKOFF: tx_count_en = 1'b0;
            default:     tx_count_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/octet_rx_track.sv
module octet_rx_track
    import octet_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic half_duplex,
    input  logic rx_byte,
    input  logic jam_start,
    input  logic frame_end,
    output logic rx_count_en,
    output logic jam_block
);

    rx_state_e state_q;
    rx_state_e state_d;
    logic      jam_now;

    assign jam_now = half_duplex & jam_start;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RXS_LIVE: begin
                if (jam_now && !frame_end) begin
                    state_d = RXS_JAM;
                end
            end
            RXS_JAM: begin
                if (frame_end) begin
                    state_d = RXS_LIVE;
                end
            end
            default: state_d = RXS_LIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RXS_LIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // output logic
    always_comb begin
        rx_count_en = 1'b0;
        jam_block   = 1'b0;
        unique case (state_q)
            RXS_LIVE: begin
                jam_block   = jam_now;
                rx_count_en = rx_byte && !jam_now;
            end
            RXS_JAM: begin
                jam_block   = 1'b1;
                rx_count_en = rx_byte && !half_duplex;
            end
            default: begin
                jam_block   = 1'b0;
                rx_count_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/octet_accum.sv
module octet_accum #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_count_en,
    input  logic             rx_count_en,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count
);

    localparam int unsigned STEP_W = $clog2(octet_cnt_pkg::MAX_STEP + 1);

    logic [STEP_W-1:0] step;
    logic [CNT_W-1:0]  sub_val;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  count_d;

    always_comb begin
        step    = STEP_W'(tx_count_en) + STEP_W'(rx_count_en);
        sub_val = wr_en ? wr_data : '0;
        count_d = count_q + CNT_W'(step) - sub_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/octet_counter_top.sv
module octet_counter_top #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             half_duplex,
    input  logic             tx_byte,
    input  logic             rx_byte,
    input  logic             collision,
    input  logic             carrier_loss,
    input  logic             jam_start,
    input  logic             frame_end,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] octet_count
);

    logic tx_count_en;
    logic rx_count_en;
    logic jam_block;

    octet_rx_track u_rx_track (
        .clk         (clk),
        .rst         (rst),
        .half_duplex (half_duplex),
        .rx_byte     (rx_byte),
        .jam_start   (jam_start),
        .frame_end   (frame_end),
        .rx_count_en (rx_count_en),
        .jam_block   (jam_block)
    );

    octet_tx_track u_tx_track (
        .clk          (clk),
        .rst          (rst),
        .tx_byte      (tx_byte),
        .collision    (collision),
        .carrier_loss (carrier_loss),
        .frame_end    (frame_end),
        .jam_block    (jam_block),
        .tx_count_en  (tx_count_en)
    );

    octet_accum #(
        .CNT_W (CNT_W)
    ) u_accum (
        .clk         (clk),
        .rst         (rst),
        .tx_count_en (tx_count_en),
        .rx_count_en (rx_count_en),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .count       (octet_count)
    );

endmodule

// File: rtl/octet_counter_chk.sv
module octet_counter_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             half_duplex,
    input logic             tx_byte,
    input logic             rx_byte,
    input logic             collision,
    input logic             carrier_loss,
    input logic             jam_start,
    input logic             wr_en,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] octet_count
);

    logic rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
    end

    always @(negedge clk) begin
        if (rst_d) begin
            AST_RESET_CLEARS: assert (octet_count == '0); // R1
        end
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!tx_byte && !rx_byte && !wr_en) |=> $stable(octet_count)); // R2

    AST_FULL_DUPLEX_RX: assert property (@(posedge clk) disable iff (rst)
        (!half_duplex && rx_byte && !tx_byte && !wr_en)
            |=> (octet_count == $past(octet_count) + 1'b1)); // R3

    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((octet_count - $past(octet_count)) <= CNT_W'(2))); // R4

    AST_CUT_BLOCKS_TX: assert property (@(posedge clk) disable iff (rst)
        ((collision || carrier_loss) && !rx_byte && !wr_en) |=> $stable(octet_count)); // R5

    AST_JAM_BLOCKS_ALL: assert property (@(posedge clk) disable iff (rst)
        (half_duplex && jam_start && !wr_en) |=> $stable(octet_count)); // R6

    AST_WRITE_NET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !tx_byte && !rx_byte)
            |=> (octet_count == $past(octet_count) - $past(wr_data))); // R7

endmodule

bind octet_counter_top octet_counter_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .half_duplex  (half_duplex),
    .tx_byte      (tx_byte),
    .rx_byte      (rx_byte),
    .collision    (collision),
    .carrier_loss (carrier_loss),
    .jam_start    (jam_start),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .octet_count  (octet_count)
);

// File: tb/octet_counter_top_tb_top.sv
module octet_counter_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        half_duplex;
    logic        tx_byte;
    logic        rx_byte;
    logic        collision;
    logic        carrier_loss;
    logic        jam_start;
    logic        frame_end;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] octet_count;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    // model state
    bit          m_backoff;
    bit          m_jam;
    logic [31:0] m_cnt;

    always #5 clk = ~clk;

    octet_counter_top dut_i (
        .clk          (clk),
        .rst          (rst),
        .half_duplex  (half_duplex),
        .tx_byte      (tx_byte),
        .rx_byte      (rx_byte),
        .collision    (collision),
        .carrier_loss (carrier_loss),
        .jam_start    (jam_start),
        .frame_end    (frame_end),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .octet_count  (octet_count)
    );

    // Expected count after one edge, from the requirements.
    function automatic logic [31:0] next_count(
        input logic [31:0] cnt, input bit backoff, input bit jam,
        input bit hd, input bit tx, input bit rx, input bit col, input bit cl,
        input bit js, input bit we, input logic [31:0] wd);
        bit tx_ok;
        bit rx_ok;
        tx_ok = tx && !backoff && !col && !cl && !jam && !(hd && js);
        rx_ok = rx && !(hd && (jam || js));
        return cnt + 32'(tx_ok) + 32'(rx_ok) - (we ? wd : 32'd0);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic cyc(input string tag, input bit hd, input bit tx, input bit rx,
                       input bit col, input bit cl, input bit js, input bit fe,
                       input bit we, input logic [31:0] wd);
        @(negedge clk);
        half_duplex = hd; tx_byte = tx; rx_byte = rx; collision = col;
        carrier_loss = cl; jam_start = js; frame_end = fe; wr_en = we; wr_data = wd;
        m_cnt = next_count(m_cnt, m_backoff, m_jam, hd, tx, rx, col, cl, js, we, wd);
        if (fe) m_backoff = 1'b0;
        else if (col || cl) m_backoff = 1'b1;
        if (fe) m_jam = 1'b0;
        else if (hd && js) m_jam = 1'b1;
        @(posedge clk);
        #2;
        check(tag, octet_count, m_cnt);
    endtask

    task automatic idle_inputs();
        half_duplex = 0; tx_byte = 0; rx_byte = 0; collision = 0; carrier_loss = 0;
        jam_start = 0; frame_end = 0; wr_en = 0; wr_data = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cnt = '0; m_backoff = 1'b0; m_jam = 1'b0;
        check("R1 reset", octet_count, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        idle_inputs();
        rst = 1'b1;
        do_reset();

        //              tag                 hd tx rx co cl js fe we wd
        cyc("R2 single tx",                 0, 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R2 idle hold",                 0, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R3 rx full duplex",            0, 0, 1, 0, 0, 0, 0, 0, 0);
        cyc("R4 tx+rx adds 2",              0, 1, 1, 0, 0, 0, 0, 0, 0);
        check("R4 value", octet_count, 32'd4);
        // collision, suppressed bytes, retry
        cyc("R2 pre-collision tx",          1, 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R5 collision cycle",           1, 1, 0, 1, 0, 0, 0, 0, 0);
        cyc("R5 backoff tx",                1, 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R5 backoff rx still counts",   1, 1, 1, 0, 0, 0, 0, 0, 0);
        cyc("R5 frame_end in backoff",      1, 1, 0, 0, 0, 0, 1, 0, 0);
        cyc("R5 retry counted",             1, 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R5 carrier loss",              0, 1, 0, 0, 1, 0, 0, 0, 0);
        cyc("R5 after carrier loss",        0, 1, 0, 0, 0, 0, 1, 0, 0);
        cyc("R5 carrier loss retry",        0, 1, 0, 0, 0, 0, 0, 0, 0);
        // jam in half duplex
        cyc("R6 jam start",                 1, 1, 1, 0, 0, 1, 0, 0, 0);
        cyc("R6 jam tx+rx",                 1, 1, 1, 0, 0, 0, 0, 0, 0);
        cyc("R6 jam end",                   1, 1, 1, 0, 0, 0, 1, 0, 0);
        cyc("R6 after jam",                 1, 1, 1, 0, 0, 0, 0, 0, 0);
        // jam ignored in full duplex
        cyc("R6 full duplex jam ignored",   0, 1, 1, 0, 0, 1, 0, 0, 0);
        cyc("R6 full duplex next",          0, 1, 1, 0, 0, 0, 0, 0, 0);
        // frame_end together with collision
        cyc("R9 col with frame_end",        0, 1, 0, 1, 0, 0, 1, 0, 0);
        cyc("R9 live next cycle",           0, 1, 0, 0, 0, 0, 0, 0, 0);
        // writes
        cyc("R7 write subtract",            0, 0, 0, 0, 0, 0, 0, 1, 32'd3);
        cyc("R7 write with +2",             0, 1, 1, 0, 0, 0, 0, 1, 32'd5);
        // wrap
        cyc("R8 wrap below zero",           0, 0, 0, 0, 0, 0, 0, 1, m_cnt + 32'd1);
        check("R8 at max", octet_count, 32'hFFFF_FFFF);
        cyc("R8 wrap over max",             0, 1, 0, 0, 0, 0, 0, 0, 0);
        check("R8 back to zero", octet_count, 32'd0);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            automatic bit hd = ($urandom % 64) != 0 ? half_duplex : !half_duplex;
            automatic bit tx = ($urandom % 4) != 0;
            automatic bit rx = ($urandom % 3) == 0;
            automatic bit co = ($urandom % 40) == 0;
            automatic bit cl = ($urandom % 90) == 0;
            automatic bit js = ($urandom % 50) == 0;
            automatic bit fe = ($urandom % 15) == 0;
            automatic bit we = ($urandom % 30) == 0;
            automatic logic [31:0] wd = (($urandom % 2) == 0) ? ($urandom % 8) : $urandom;
            cyc("R2 R3 R4 R5 R6 R7 random", hd, tx, rx, co, cl, js, fe, we, wd);
        end

        do_reset();
        cyc("R1 counts after reset",        0, 1, 1, 0, 0, 0, 0, 0, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule